// File: doc/BRIEF.md
# 16-bit multi-operand execute unit

This block is the arithmetic stage of a small 16-bit core. Each cycle it takes a 4-bit major function code, a 4-bit sub-function code, three 16-bit signed register operands (a, b, c) and an 8-bit immediate. It computes the value that the core writes back to register c. The ALU work falls into three classes. Unary operations on a are selected by the sub-function when the major code is zero. Two-operand operations combine b with a. Three-operand operations also use c: a conditional move, a conditional add, and insertion of the immediate into either byte of c.

The result is captured in an output register, so it appears one clock after the operands are presented. Next to the result there are two flags. A valid flag tells the core whether a register write should happen; it is low for the major-zero sub-functions that are not ALU operations. A divide-by-zero flag is also provided. Memory access and program-counter updates are handled elsewhere.

Top module: `sm_exec_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result`, `result_valid` and `div_zero` are all cleared to 0 on that edge.
- R2: Outputs are registered. Operands presented before a rising edge appear on the outputs after that edge and stay there until the next edge.
- R3: With major code 0, sub-functions 9 to 13 yield: bitwise inverse of a (9), two's-complement negative of a (10), 1 if a is zero and otherwise 0 (11), count of set bits in a (12), and a with its bit order reversed (13). `result_valid` is 1 for all of them.
- R4: Major codes 1, 2 and 3 yield b+a, b−a and b×a, each as the low 16 bits with wrap-around.
- R5: Major code 4 yields the signed quotient b÷a, truncated toward zero. The case −32768 ÷ −1 yields −32768.
- R6: Major code 4 with a equal to 0 yields result 0 with `div_zero` = 1. In every other case `div_zero` is 0.
- R7: Major codes 5, 6 and 7 yield b XOR a, b AND a and b OR a.
- R8: Major code 8 shifts b left and major code 9 shifts b right arithmetically (the sign is copied in). The shift amount is only a[3:0].
- R9: Major code 10 yields 1 when b<a and major code 11 yields 1 when b≤a. Both compare as signed values, and both yield 0 otherwise.
- R10: Major code 12 yields a if b is nonzero and c otherwise. Major code 13 yields a+c if b is nonzero and c otherwise.
- R11: Major code 14 yields {c[15:8], imm}. Major code 15 yields {imm, c[7:0]}.
- R12: With major code 0 and a sub-function outside 9 to 13, `result_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fn_major | input | 4 | Major function code |
| fn_sub | input | 4 | Sub-function code, used when major is 0 |
| opnd_a | input | 16 | Operand a (signed) |
| opnd_b | input | 16 | Operand b (signed) |
| opnd_c | input | 16 | Operand c (signed), also the destination's old value |
| imm | input | 8 | Immediate byte |
| result | output | 16 | Registered result for register c |
| result_valid | output | 1 | Registered: result should be written |
| div_zero | output | 1 | Registered: division by zero occurred |

## Verification
The bench builds the unit with the default 16-bit data width. At that width the immediate is 8 bits and the shift amount is 4 bits, so the byte insertions split c at bit 8 and a shift amount of 0x13 must act as 3. The default width also makes the extreme signed values 0x8000 and 0xFFFF reachable in the vectors. Those values exercise the wrap of negation, overflow of the most-negative quotient, signed comparisons across zero, and sign copying in the right shift.

// File: rtl/sm_exec_pkg.sv
package sm_exec_pkg;
  localparam int FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    MJ_MISC  = 4'd0,
    MJ_ADD   = 4'd1,
    MJ_SUB   = 4'd2,
    MJ_MUL   = 4'd3,
    MJ_DIV   = 4'd4,
    MJ_XOR   = 4'd5,
    MJ_AND   = 4'd6,
    MJ_OR    = 4'd7,
    MJ_SHL   = 4'd8,
    MJ_SHR   = 4'd9,
    MJ_LT    = 4'd10,
    MJ_LE    = 4'd11,
    MJ_CMOV  = 4'd12,
    MJ_CADD  = 4'd13,
    MJ_IMMLO = 4'd14,
    MJ_IMMHI = 4'd15
  } major_e;

  typedef enum logic [FN_W-1:0] {
    SB_INV  = 4'd9,
    SB_NEG  = 4'd10,
    SB_LNOT = 4'd11,
    SB_POP  = 4'd12,
    SB_REV  = 4'd13
  } sub_e;
endpackage

// File: rtl/exu_unary.sv
module exu_unary
  import sm_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [FN_W-1:0]   sub,
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] y,
  output logic              hit
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  // ripple chain of set-bit counts
  logic [CNT_W-1:0]  pc_acc [DATA_W+1];
  logic [DATA_W-1:0] rev;

  assign pc_acc[0] = '0;
  for (genvar i = 0; i < DATA_W; i++) begin : g_bits
    assign pc_acc[i+1] = pc_acc[i] + {{(CNT_W-1){1'b0}}, a[i]};
    assign rev[i]      = a[DATA_W-1-i];
  end

  always_comb begin
    y   = '0;
    hit = 1'b1;
    case (sub)
      SB_INV:  y = ~a;
      SB_NEG:  y = '0 - a;
      SB_LNOT: y[0] = (a == '0);
      SB_POP:  y = {{(DATA_W-CNT_W){1'b0}}, pc_acc[DATA_W]};
      SB_REV:  y = rev;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/exu_binary.sv
module exu_binary
  import sm_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [FN_W-1:0]   major,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] shr;

  assign amt = a[SH_W-1:0];
  assign shr = $unsigned($signed(b) >>> amt);

  always_comb begin
    y = '0;
    case (major)
      MJ_ADD: y = b + a;
      MJ_SUB: y = b - a;
      MJ_MUL: y = b * a;
      MJ_XOR: y = b ^ a;
      MJ_AND: y = b & a;
      MJ_OR:  y = b | a;
      MJ_SHL: y = b << amt;
      MJ_SHR: y = shr;
      MJ_LT:  y[0] = ($signed(b) <  $signed(a));
      MJ_LE:  y[0] = ($signed(b) <= $signed(a));
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/exu_divide.sv
module exu_divide #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] q,
  output logic              dz
);
  logic signed [DATA_W-1:0] sa, sb, sq;

  assign sa = $signed(a);
  assign sb = $signed(b);
  assign sq = sb / sa;

  always_comb begin
    dz = 1'b0;
    if (a == '0) begin
      q  = '0;
      dz = 1'b1;
    end else if (a == '1) begin
      // divisor -1: plain negation, wraps for the most negative value
      q = '0 - b;
    end else begin
      q = $unsigned(sq);
    end
  end
endmodule

// File: rtl/exu_ternary.sv
module exu_ternary
  import sm_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [FN_W-1:0]     major,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic [DATA_W-1:0]   c,
  input  logic [DATA_W/2-1:0] imm,
  output logic [DATA_W-1:0]   y
);
  localparam int HALF = DATA_W / 2;

  logic cond;
  assign cond = (b != '0);

  always_comb begin
    case (major)
      MJ_CMOV:  y = cond ? a : c;
      MJ_CADD:  y = cond ? (a + c) : c;
      MJ_IMMLO: y = {c[DATA_W-1:HALF], imm};
      MJ_IMMHI: y = {imm, c[HALF-1:0]};
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/sm_exec_unit.sv
module sm_exec_unit
  import sm_exec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FN_W-1:0]     fn_major,
  input  logic [FN_W-1:0]     fn_sub,
  input  logic [DATA_W-1:0]   opnd_a,
  input  logic [DATA_W-1:0]   opnd_b,
  input  logic [DATA_W-1:0]   opnd_c,
  input  logic [DATA_W/2-1:0] imm,
  output logic [DATA_W-1:0]   result,
  output logic                result_valid,
  output logic                div_zero
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] un_y, bin_y, div_q, ter_y;
  logic              un_hit, div_dz;
  logic [DATA_W-1:0] res_nx;
  logic              vld_nx, dz_nx;

  exu_unary #(.DATA_W(DATA_W)) u_unary (
    .sub(fn_sub), .a(opnd_a), .y(un_y), .hit(un_hit)
  );

  exu_binary #(.DATA_W(DATA_W)) u_binary (
    .major(fn_major), .a(opnd_a), .b(opnd_b), .y(bin_y)
  );

  exu_divide #(.DATA_W(DATA_W)) u_divide (
    .a(opnd_a), .b(opnd_b), .q(div_q), .dz(div_dz)
  );

  exu_ternary #(.DATA_W(DATA_W)) u_ternary (
    .major(fn_major), .a(opnd_a), .b(opnd_b), .c(opnd_c),
    .imm(imm), .y(ter_y)
  );

  always_comb begin
    vld_nx = 1'b1;
    dz_nx  = 1'b0;
    case (fn_major)
      MJ_MISC: begin
        vld_nx = un_hit;
        res_nx = un_y;
      end
      MJ_DIV: begin
        res_nx = div_q;
        dz_nx  = div_dz;
      end
      MJ_CMOV, MJ_CADD, MJ_IMMLO, MJ_IMMHI: res_nx = ter_y;
      default: res_nx = bin_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      result_valid <= 1'b0;
      div_zero     <= 1'b0;
    end else begin
      result       <= res_nx;
      result_valid <= vld_nx;
      div_zero     <= dz_nx;
    end
  end

  assert_invalid_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> (result == '0) && !div_zero);

  assert_dz_zero_result_R6: assert property (@(posedge clk) disable iff (rst)
    div_zero |-> (result == '0) && result_valid);

  assert_dz_raised_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && fn_major == MJ_DIV && opnd_a == '0) |-> div_zero);

  assert_popcount_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && fn_major == MJ_MISC && fn_sub == SB_POP)
      |-> result == DATA_W'($countones($past(opnd_a))));

  assert_compare_bool_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && (fn_major == MJ_LT || fn_major == MJ_LE))
      |-> result[DATA_W-1:1] == '0 && result_valid);

  assert_immlo_R11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && fn_major == MJ_IMMLO)
      |-> result == {$past(opnd_c[DATA_W-1:HALF]), $past(imm)});

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> result == '0 && !result_valid && !div_zero);
endmodule

// File: tb/sm_exec_unit_bench.sv
`timescale 1ns/1ps
module sm_exec_unit_bench;
  typedef struct packed {
    logic [3:0]  mj;
    logic [3:0]  sb;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] c;
    logic [7:0]  im;
    logic [15:0] y;
    logic        v;
    logic        dz;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    '{4'd1, 4'd0, 16'h0003, 16'h0005, 16'h0000, 8'h00, 16'h0008, 1'b1, 1'b0},
    '{4'd1, 4'd0, 16'h0001, 16'h7FFF, 16'h0000, 8'h00, 16'h8000, 1'b1, 1'b0},
    '{4'd2, 4'd0, 16'h0005, 16'h0003, 16'h0000, 8'h00, 16'hFFFE, 1'b1, 1'b0},
    '{4'd3, 4'd0, 16'h0100, 16'h0100, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0},
    '{4'd3, 4'd0, 16'h0007, 16'hFFFD, 16'h0000, 8'h00, 16'hFFEB, 1'b1, 1'b0},
    '{4'd4, 4'd0, 16'h0002, 16'hFFF9, 16'h0000, 8'h00, 16'hFFFD, 1'b1, 1'b0},
    '{4'd4, 4'd0, 16'hFFFE, 16'h0007, 16'h0000, 8'h00, 16'hFFFD, 1'b1, 1'b0},
    '{4'd4, 4'd0, 16'hFFFF, 16'h8000, 16'h0000, 8'h00, 16'h8000, 1'b1, 1'b0},
    '{4'd4, 4'd0, 16'h0000, 16'h1234, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b1},
    '{4'd4, 4'd0, 16'h0003, 16'h0064, 16'h0000, 8'h00, 16'h0021, 1'b1, 1'b0},
    '{4'd5, 4'd0, 16'hFF00, 16'hF0F0, 16'h0000, 8'h00, 16'h0FF0, 1'b1, 1'b0},
    '{4'd6, 4'd0, 16'hFF00, 16'hF0F0, 16'h0000, 8'h00, 16'hF000, 1'b1, 1'b0},
    '{4'd7, 4'd0, 16'hFF00, 16'hF0F0, 16'h0000, 8'h00, 16'hFFF0, 1'b1, 1'b0},
    '{4'd8, 4'd0, 16'h0013, 16'h0001, 16'h0000, 8'h00, 16'h0008, 1'b1, 1'b0},
    '{4'd8, 4'd0, 16'h000F, 16'h0001, 16'h0000, 8'h00, 16'h8000, 1'b1, 1'b0},
    '{4'd9, 4'd0, 16'h0014, 16'h8000, 16'h0000, 8'h00, 16'hF800, 1'b1, 1'b0},
    '{4'd9, 4'd0, 16'h0004, 16'h0100, 16'h0000, 8'h00, 16'h0010, 1'b1, 1'b0},
    '{4'd10,4'd0, 16'h0001, 16'hFFFF, 16'h0000, 8'h00, 16'h0001, 1'b1, 1'b0},
    '{4'd10,4'd0, 16'h0005, 16'h0005, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0},
    '{4'd11,4'd0, 16'h0005, 16'h0005, 16'h0000, 8'h00, 16'h0001, 1'b1, 1'b0},
    '{4'd11,4'd0, 16'hFFFF, 16'h0001, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0},
    '{4'd12,4'd0, 16'h1111, 16'h0001, 16'h2222, 8'h00, 16'h1111, 1'b1, 1'b0},
    '{4'd12,4'd0, 16'h1111, 16'h0000, 16'h2222, 8'h00, 16'h2222, 1'b1, 1'b0},
    '{4'd13,4'd0, 16'h0010, 16'h8000, 16'h0020, 8'h00, 16'h0030, 1'b1, 1'b0},
    '{4'd13,4'd0, 16'h0010, 16'h0000, 16'h0020, 8'h00, 16'h0020, 1'b1, 1'b0},
    '{4'd14,4'd0, 16'h0000, 16'h0000, 16'hABCD, 8'h5A, 16'hAB5A, 1'b1, 1'b0},
    '{4'd15,4'd0, 16'h0000, 16'h0000, 16'hABCD, 8'h5A, 16'h5ACD, 1'b1, 1'b0},
    '{4'd0, 4'd9, 16'h00FF, 16'h0000, 16'h0000, 8'h00, 16'hFF00, 1'b1, 1'b0},
    '{4'd0, 4'd10,16'h0001, 16'h0000, 16'h0000, 8'h00, 16'hFFFF, 1'b1, 1'b0},
    '{4'd0, 4'd10,16'h8000, 16'h0000, 16'h0000, 8'h00, 16'h8000, 1'b1, 1'b0},
    '{4'd0, 4'd11,16'h0000, 16'h0000, 16'h0000, 8'h00, 16'h0001, 1'b1, 1'b0},
    '{4'd0, 4'd11,16'h0100, 16'h0000, 16'h0000, 8'h00, 16'h0000, 1'b1, 1'b0},
    '{4'd0, 4'd12,16'hF0F1, 16'h0000, 16'h0000, 8'h00, 16'h0009, 1'b1, 1'b0},
    '{4'd0, 4'd12,16'hFFFF, 16'h0000, 16'h0000, 8'h00, 16'h0010, 1'b1, 1'b0},
    '{4'd0, 4'd13,16'h0001, 16'h0000, 16'h0000, 8'h00, 16'h8000, 1'b1, 1'b0},
    '{4'd0, 4'd13,16'h1234, 16'h0000, 16'h0000, 8'h00, 16'h2C48, 1'b1, 1'b0},
    '{4'd0, 4'd0, 16'h1234, 16'h5678, 16'h9ABC, 8'hFF, 16'h0000, 1'b0, 1'b0},
    '{4'd0, 4'd1, 16'h1234, 16'h5678, 16'h9ABC, 8'hFF, 16'h0000, 1'b0, 1'b0},
    '{4'd0, 4'd8, 16'h1234, 16'h5678, 16'h9ABC, 8'hFF, 16'h0000, 1'b0, 1'b0},
    '{4'd0, 4'd14,16'h0000, 16'h5678, 16'h9ABC, 8'hFF, 16'h0000, 1'b0, 1'b0},
    '{4'd0, 4'd15,16'h0000, 16'h5678, 16'h9ABC, 8'hFF, 16'h0000, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  fn_major = '0, fn_sub = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
  logic [7:0]  imm = '0;
  logic [15:0] result;
  logic        result_valid, div_zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  sm_exec_unit u_sm_exec_unit (
    .clk(clk), .rst(rst), .fn_major(fn_major), .fn_sub(fn_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .imm(imm),
    .result(result), .result_valid(result_valid), .div_zero(div_zero)
  );

  function automatic string req_of(vec_t t);
    case (t.mj)
      4'd0:               return (t.sb >= 4'd9 && t.sb <= 4'd13) ? "R3" : "R12";
      4'd1, 4'd2, 4'd3:   return "R4";
      4'd4:               return (t.a == 16'h0) ? "R6" : "R5";
      4'd5, 4'd6, 4'd7:   return "R7";
      4'd8, 4'd9:         return "R8";
      4'd10, 4'd11:       return "R9";
      4'd12, 4'd13:       return "R10";
      default:            return "R11";
    endcase
  endfunction

  task automatic drive(vec_t t);
    fn_major = t.mj; fn_sub = t.sb;
    opnd_a = t.a; opnd_b = t.b; opnd_c = t.c; imm = t.im;
  endtask

  task automatic check(string req, logic [17:0] got, logic [17:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got result=%h valid=%b dz=%b, expected result=%h valid=%b dz=%b",
               req, got[17:2], got[1], got[0], exp[17:2], exp[1], exp[0]);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2: watchdog got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset with an active operation on the inputs
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    check("R1", {result, result_valid, div_zero}, 18'h0);
    rst = 1'b0;

    // table walk: drive at a falling edge, sample at the next falling edge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      check(req_of(VEC[i]), {result, result_valid, div_zero},
            {VEC[i].y, VEC[i].v, VEC[i].dz});
    end

    // R2: back-to-back, output holds until the next edge
    @(negedge clk);
    drive(VEC[0]);                         // 3+5 -> 8
    @(negedge clk);
    drive(VEC[2]);                         // 3-5 -> FFFE
    #1;
    check("R2", {result, result_valid, div_zero}, {16'h0008, 1'b1, 1'b0});
    @(negedge clk);
    check("R2", {result, result_valid, div_zero}, {16'hFFFE, 1'b1, 1'b0});

    // R6: flag clears on the division right after a divide by zero
    drive(VEC[8]);
    @(negedge clk);
    check("R6", {result, result_valid, div_zero}, {16'h0000, 1'b1, 1'b1});
    drive(VEC[9]);
    @(negedge clk);
    check("R6", {result, result_valid, div_zero}, {16'h0021, 1'b1, 1'b0});

    // R1: reset in mid-stream with a divide by zero on the inputs
    drive(VEC[8]);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {result, result_valid, div_zero}, 18'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R6", {result, result_valid, div_zero}, {16'h0000, 1'b1, 1'b1});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule